// File: doc/BRIEF.md
# BCD Time and Calendar Counter

This block holds wall-clock time and the calendar as seven packed-BCD byte registers: seconds, minutes, hours, day of week, day of month, month (with a century flag in its top bit) and year. A free-running sub-second tick enters a small prescaler. Every `TICKS_PER_SEC` ticks the prescaler emits one advance, and the advance ripples through the fields with correct month lengths and leap-year handling. The hours byte carries its own format selector, so software can choose between a 24-hour count and a 12-hour count with a PM flag.

A host interface writes any register through a one-hot strobe vector and a shared data byte. A write to seconds also restarts the prescaler, so that a full second passes before the next advance. All registers are visible at the ports at all times. Reset loads midnight of day 01, month 01, year 00, with day of week 01 and the century flag clear.

Top module: `bcd_calendar`

## Requirements
- R1: After reset, the seven outputs are seconds 0x00, minutes 0x00, hours 0x00 (24-hour format), day of week 0x01, date 0x01, month 0x01 (century 0) and year 0x00.
- R2: Unused bits read as 0. The write masks are: seconds and minutes 0x7F, hours 0x7F, day of week 0x07, date 0x3F, month 0x9F, year 0xFF.
- R3: On each advance, seconds count 00–59 in BCD. The step from 59 to 00 carries into minutes, which count 00–59 in the same way, and the minutes step from 59 to 00 carries into hours.
- R4: When hours bit 6 is 0 (24-hour format), hours count 00–23 in BCD. The step from 23 to 00 is midnight and advances the date and the day of week.
- R5: When hours bit 6 is 1 (12-hour format), bits 4:0 count 12, 01 … 11 and bit 5 is the PM flag (1 = PM). The flag toggles on the step from 11 to 12, and the step from 11 PM to 12 AM is midnight.
- R6: At midnight the date wraps to 01 and the month advances after 30 in months 04, 06, 09 and 11, and after 31 in the other months.
- R7: February ends after 29 when the century flag (month bit 7) is 0, and after 28 when it is 1.
- R8: At the end of month 12, the month wraps to 01 and the year advances. The step from year 99 to 00 toggles the century flag.
- R9: Day of week counts 1 to 7 and wraps to 1. It advances at midnight, together with the date.
- R10: One advance occurs per `TICKS_PER_SEC` sub-second ticks. A seconds write restarts the prescaler: the next advance comes on the `TICKS_PER_SEC`-th tick after the write, and a tick in the write cycle itself does not count.
- R11: Strobe bit n of `wr_en_i` writes register n (0 seconds, 1 minutes, 2 hours, 3 day of week, 4 date, 5 month, 6 year). The value appears one cycle later and overrides any count of that register in the same cycle, while the carries into other registers still take effect.
- R12: A field at or above its top value (for example seconds 0x7F) wraps to its first value on the next advance, so illegal BCD never locks the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | Sub-second tick, one cycle wide |
| wr_en_i | input | 7 | One-hot register write strobes |
| wr_data_i | input | 8 | Write data byte |
| sec_o | output | 8 | Seconds, BCD |
| min_o | output | 8 | Minutes, BCD |
| hour_o | output | 8 | Hours with format and PM bits |
| dow_o | output | 8 | Day of week 1–7 |
| date_o | output | 8 | Day of month, BCD |
| month_o | output | 8 | Month, BCD, century flag in bit 7 |
| year_o | output | 8 | Year, BCD |

## Verification
All state is the visible register set, so a wrong carry, a wrong month length or a lost PM flip shows at the ports in the very cycle the advance lands. A slip in the prescaler count shows one tick early or late on the seconds output. The bench therefore compares all seven bytes after every cycle against a decimal model that holds the hour as 0–23. A mistake in the 12-hour encoding, or in the century rule for February, appears as a byte mismatch at the first midnight or noon that crosses the faulty path.

// File: rtl/cal_pkg.sv
package cal_pkg;

    typedef logic [7:0] bcd8_t;

    localparam int NUM_REGS = 7;
    localparam int REG_SEC   = 0;
    localparam int REG_MIN   = 1;
    localparam int REG_HOUR  = 2;
    localparam int REG_DOW   = 3;
    localparam int REG_DATE  = 4;
    localparam int REG_MONTH = 5;
    localparam int REG_YEAR  = 6;

    localparam bcd8_t MASK_SEC   = 8'h7F;
    localparam bcd8_t MASK_MIN   = 8'h7F;
    localparam bcd8_t MASK_HOUR  = 8'h7F;
    localparam bcd8_t MASK_DOW   = 8'h07;
    localparam bcd8_t MASK_DATE  = 8'h3F;
    localparam bcd8_t MASK_MONTH = 8'h9F;
    localparam bcd8_t MASK_YEAR  = 8'hFF;

    typedef struct packed {
        bcd8_t sec;
        bcd8_t min;
        bcd8_t hour;
    } tod_state_t;

    typedef struct packed {
        bcd8_t dow;
        bcd8_t date;
        bcd8_t month;
        bcd8_t year;
    } cal_state_t;

    // Add one to a packed BCD byte; a low digit of 9 or above wraps.
    function automatic bcd8_t bcd_inc(input bcd8_t v);
        if (v[3:0] >= 4'd9) begin
            return {v[7:4] + 4'd1, 4'd0};
        end
        return v + 8'd1;
    endfunction

    // Advance with wrap: any value at or above top restarts at first.
    function automatic bcd8_t bcd_step(input bcd8_t v, input bcd8_t top, input bcd8_t first);
        if (v >= top) begin
            return first;
        end
        return bcd_inc(v);
    endfunction

    // Last day of a month in BCD; century flag set means a short February.
    function automatic bcd8_t month_len(input logic [4:0] m, input logic cent);
        case (m)
            5'h02:                      return cent ? 8'h28 : 8'h29;
            5'h04, 5'h06, 5'h09, 5'h11: return 8'h30;
            default:                    return 8'h31;
        endcase
    endfunction

endpackage

// File: rtl/cal_prescaler.sv
module cal_prescaler #(
    parameter int TICKS_PER_SEC = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic clear_i,
    output logic step_o
);

    generate
        if (TICKS_PER_SEC <= 1) begin : g_direct
            assign step_o = tick_i && !clear_i;
        end else begin : g_count
            localparam int CW = $clog2(TICKS_PER_SEC);
            localparam logic [CW-1:0] LAST = CW'(TICKS_PER_SEC - 1);

            logic [CW-1:0] cnt_d, cnt_q;
            logic          step_c;

            always_comb begin
                cnt_d  = cnt_q;
                step_c = 1'b0;
                if (clear_i) begin
                    cnt_d = '0;
                end else if (tick_i) begin
                    if (cnt_q == LAST) begin
                        cnt_d  = '0;
                        step_c = 1'b1;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
            end

            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    cnt_q <= '0;
                end else begin
                    cnt_q <= cnt_d;
                end
            end

            assign step_o = step_c;

            p_cnt_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
                cnt_q <= LAST);

            p_clear_restarts_r10: assert property (@(posedge clk) disable iff (!rst_n)
                clear_i |=> (cnt_q == '0));
        end
    endgenerate

endmodule

// File: rtl/cal_time_of_day.sv
module cal_time_of_day
    import cal_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       step_i,
    input  logic [2:0] wr_en_i,
    input  bcd8_t      wr_data_i,
    output bcd8_t      sec_o,
    output bcd8_t      min_o,
    output bcd8_t      hour_o,
    output logic       day_step_o
);

    tod_state_t state_d, state_q;

    logic  carry_min, carry_hour;
    logic  fmt12, pm;
    bcd8_t h12, h24;

    always_comb begin
        state_d    = state_q;
        day_step_o = 1'b0;
        carry_min  = state_q.sec >= 8'h59;
        carry_hour = carry_min && (state_q.min >= 8'h59);
        fmt12      = state_q.hour[6];
        pm         = state_q.hour[5];
        h12        = {3'b000, state_q.hour[4:0]};
        h24        = {2'b00, state_q.hour[5:0]};

        if (step_i) begin
            state_d.sec = bcd_step(state_q.sec, 8'h59, 8'h00);
            if (carry_min) begin
                state_d.min = bcd_step(state_q.min, 8'h59, 8'h00);
            end
            if (carry_hour) begin
                if (fmt12) begin
                    if (h12 == 8'h11) begin
                        state_d.hour = {2'b01, !pm, 5'h12};
                        day_step_o   = pm;
                    end else if (h12 >= 8'h12) begin
                        state_d.hour = {2'b01, pm, 5'h01};
                    end else begin
                        state_d.hour = {2'b01, pm, 5'(bcd_inc(h12))};
                    end
                end else begin
                    if (h24 >= 8'h23) begin
                        state_d.hour = 8'h00;
                        day_step_o   = 1'b1;
                    end else begin
                        state_d.hour = {2'b00, 6'(bcd_inc(h24))};
                    end
                end
            end
        end

        if (wr_en_i[0]) state_d.sec  = wr_data_i & MASK_SEC;
        if (wr_en_i[1]) state_d.min  = wr_data_i & MASK_MIN;
        if (wr_en_i[2]) state_d.hour = wr_data_i & MASK_HOUR;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '{sec: 8'h00, min: 8'h00, hour: 8'h00};
        end else begin
            state_q <= state_d;
        end
    end

    assign sec_o  = state_q.sec;
    assign min_o  = state_q.min;
    assign hour_o = state_q.hour;

    p_sec_moves_on_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q.sec != $past(state_q.sec)) && !$past(wr_en_i[0]) |-> $past(step_i));

    p_sec_legal_after_step_r12: assert property (@(posedge clk) disable iff (!rst_n)
        step_i && !wr_en_i[0] |=> state_q.sec <= 8'h59);

    p_pm_flip_r5: assert property (@(posedge clk) disable iff (!rst_n)
        state_q.hour[6] && $past(state_q.hour[6]) && !$past(wr_en_i[2]) &&
        ($past(state_q.hour[4:0]) == 5'h11) && (state_q.hour[4:0] == 5'h12)
        |-> state_q.hour[5] != $past(state_q.hour[5]));

    p_midnight_24h_r4: assert property (@(posedge clk) disable iff (!rst_n)
        day_step_o && !wr_en_i[2] && !state_q.hour[6] |=> state_q.hour == 8'h00);

    p_top_bit_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !state_q.sec[7] && !state_q.min[7] && !state_q.hour[7]);

endmodule

// File: rtl/cal_calendar.sv
module cal_calendar
    import cal_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       day_step_i,
    input  logic [3:0] wr_en_i,
    input  bcd8_t      wr_data_i,
    output bcd8_t      dow_o,
    output bcd8_t      date_o,
    output bcd8_t      month_o,
    output bcd8_t      year_o
);

    cal_state_t state_d, state_q;

    bcd8_t last_day, mon5;
    logic  cent, carry_mon, carry_year;

    always_comb begin
        state_d    = state_q;
        cent       = state_q.month[7];
        mon5       = {3'b000, state_q.month[4:0]};
        last_day   = month_len(state_q.month[4:0], cent);
        carry_mon  = state_q.date >= last_day;
        carry_year = carry_mon && (mon5 >= 8'h12);

        if (day_step_i) begin
            state_d.dow  = (state_q.dow >= 8'h07) ? 8'h01 : state_q.dow + 8'h01;
            state_d.date = bcd_step(state_q.date, last_day, 8'h01);
            if (carry_mon) begin
                state_d.month = {cent, 2'b00, 5'(bcd_step(mon5, 8'h12, 8'h01))};
            end
            if (carry_year) begin
                state_d.year = bcd_step(state_q.year, 8'h99, 8'h00);
                if (state_q.year >= 8'h99) begin
                    state_d.month[7] = !cent;
                end
            end
        end

        if (wr_en_i[0]) state_d.dow   = wr_data_i & MASK_DOW;
        if (wr_en_i[1]) state_d.date  = wr_data_i & MASK_DATE;
        if (wr_en_i[2]) state_d.month = wr_data_i & MASK_MONTH;
        if (wr_en_i[3]) state_d.year  = wr_data_i & MASK_YEAR;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '{dow: 8'h01, date: 8'h01, month: 8'h01, year: 8'h00};
        end else begin
            state_q <= state_d;
        end
    end

    assign dow_o   = state_q.dow;
    assign date_o  = state_q.date;
    assign month_o = state_q.month;
    assign year_o  = state_q.year;

    p_dow_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
        day_step_i && !wr_en_i[0] |=> (state_q.dow >= 8'h01) && (state_q.dow <= 8'h07));

    p_century_toggle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q.year == 8'h00) && ($past(state_q.year) == 8'h99) &&
        !$past(wr_en_i[3]) && !$past(wr_en_i[2])
        |-> state_q.month[7] != $past(state_q.month[7]));

    p_unused_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q.dow[7:3] == 5'd0) && (state_q.date[7:6] == 2'd0) &&
        (state_q.month[6:5] == 2'd0));

endmodule

// File: rtl/bcd_calendar.sv
module bcd_calendar
    import cal_pkg::*;
#(
    parameter int TICKS_PER_SEC = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick_i,
    input  logic [NUM_REGS-1:0] wr_en_i,
    input  logic [7:0]          wr_data_i,
    output logic [7:0]          sec_o,
    output logic [7:0]          min_o,
    output logic [7:0]          hour_o,
    output logic [7:0]          dow_o,
    output logic [7:0]          date_o,
    output logic [7:0]          month_o,
    output logic [7:0]          year_o
);

    logic sec_step;
    logic day_step;

    cal_prescaler #(
        .TICKS_PER_SEC(TICKS_PER_SEC)
    ) u_prescaler (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_i  (tick_i),
        .clear_i (wr_en_i[REG_SEC]),
        .step_o  (sec_step)
    );

    cal_time_of_day u_tod (
        .clk        (clk),
        .rst_n      (rst_n),
        .step_i     (sec_step),
        .wr_en_i    (wr_en_i[REG_HOUR:REG_SEC]),
        .wr_data_i  (wr_data_i),
        .sec_o      (sec_o),
        .min_o      (min_o),
        .hour_o     (hour_o),
        .day_step_o (day_step)
    );

    cal_calendar u_cal (
        .clk        (clk),
        .rst_n      (rst_n),
        .day_step_i (day_step),
        .wr_en_i    (wr_en_i[REG_YEAR:REG_DOW]),
        .wr_data_i  (wr_data_i),
        .dow_o      (dow_o),
        .date_o     (date_o),
        .month_o    (month_o),
        .year_o     (year_o)
    );

endmodule

// File: tb/test_bcd_calendar.sv
module test_bcd_calendar;

    localparam int T = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_i = 1'b0;
    logic [6:0] wr_en_i = '0;
    logic [7:0] wr_data_i = '0;
    logic [7:0] sec_o, min_o, hour_o, dow_o, date_o, month_o, year_o;

    always #4 clk = ~clk;

    bcd_calendar #(.TICKS_PER_SEC(T)) i_bcd_calendar (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .wr_en_i(wr_en_i), .wr_data_i(wr_data_i),
        .sec_o(sec_o), .min_o(min_o), .hour_o(hour_o), .dow_o(dow_o),
        .date_o(date_o), .month_o(month_o), .year_o(year_o)
    );

    int n_chk = 0;
    int n_fail = 0;

    // Decimal reference model
    int m_sec, m_min, m_hr24, m_dow, m_date, m_mon, m_year, m_cnt;
    bit m_fmt12, m_cent;

    function automatic logic [7:0] to_bcd(input int v);
        return {4'(v / 10), 4'(v % 10)};
    endfunction

    function automatic int from_bcd(input logic [7:0] b);
        return int'(b[7:4]) * 10 + int'(b[3:0]);
    endfunction

    function automatic int days_in(input int mon, input bit cent);
        if (mon == 2) return cent ? 28 : 29;
        if (mon == 4 || mon == 6 || mon == 9 || mon == 11) return 30;
        return 31;
    endfunction

    function automatic logic [7:0] hour_byte(input bit fmt12, input int hr24);
        int h;
        if (!fmt12) return to_bcd(hr24);
        h = hr24 % 12;
        if (h == 0) h = 12;
        return {1'b0, 1'b1, (hr24 >= 12), to_bcd(h)[4:0]};
    endfunction

    function automatic logic [55:0] expected();
        return {to_bcd(m_sec), to_bcd(m_min), hour_byte(m_fmt12, m_hr24), to_bcd(m_dow),
                to_bcd(m_date), {m_cent, 2'b00, to_bcd(m_mon)[4:0]}, to_bcd(m_year)};
    endfunction

    task automatic model_advance();
        m_sec++;
        if (m_sec < 60) return;
        m_sec = 0; m_min++;
        if (m_min < 60) return;
        m_min = 0; m_hr24++;
        if (m_hr24 < 24) return;
        m_hr24 = 0;
        m_dow = (m_dow >= 7) ? 1 : m_dow + 1;
        m_date++;
        if (m_date <= days_in(m_mon, m_cent)) return;
        m_date = 1; m_mon++;
        if (m_mon <= 12) return;
        m_mon = 1; m_year++;
        if (m_year <= 99) return;
        m_year = 0; m_cent = !m_cent;
    endtask

    task automatic model_write(input int idx, input logic [7:0] d);
        logic [7:0] dm;
        case (idx)
            0: m_sec = from_bcd(d & 8'h7F);
            1: m_min = from_bcd(d & 8'h7F);
            2: begin
                dm = d & 8'h7F;
                m_fmt12 = dm[6];
                if (dm[6]) m_hr24 = (from_bcd({3'b000, dm[4:0]}) % 12) + (dm[5] ? 12 : 0);
                else       m_hr24 = from_bcd({2'b00, dm[5:0]});
            end
            3: m_dow = int'(d[2:0]);
            4: m_date = from_bcd(d & 8'h3F);
            5: begin m_cent = d[7]; m_mon = from_bcd({3'b000, d[4:0]}); end
            default: m_year = from_bcd(d);
        endcase
    endtask

    task automatic check(input string tag, input logic [55:0] act, input logic [55:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [55:0] dut_regs();
        return {sec_o, min_o, hour_o, dow_o, date_o, month_o, year_o};
    endfunction

    // One clock: drive at negedge, update model after the edge, then compare.
    task automatic cycle(input bit tk, input logic [6:0] we, input logic [7:0] d,
                         input bit chk, input string tag);
        bit step;
        @(negedge clk);
        tick_i = tk; wr_en_i = we; wr_data_i = d;
        @(posedge clk);
        #1;
        tick_i = 1'b0; wr_en_i = '0;
        step = tk && !we[0] && (m_cnt == T - 1);
        if (we[0]) m_cnt = 0;
        else if (tk) m_cnt = (m_cnt == T - 1) ? 0 : m_cnt + 1;
        if (step) model_advance();
        for (int i = 0; i < 7; i++) if (we[i]) model_write(i, d);
        if (chk) check(tag, dut_regs(), expected());
    endtask

    task automatic set_reg(input int idx, input logic [7:0] d, input string tag);
        cycle(1'b0, 7'(1 << idx), d, 1'b1, tag);
    endtask

    task automatic run(input int n, input string tag);
        for (int i = 0; i < n; i++) cycle(1'b1, '0, '0, 1'b1, tag);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        #(8 * 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        int r;
        r = $urandom(1234);
        m_sec = 0; m_min = 0; m_hr24 = 0; m_dow = 1; m_date = 1; m_mon = 1;
        m_year = 0; m_cnt = 0; m_fmt12 = 0; m_cent = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        #1;
        // R1 reset state
        check("R1", dut_regs(), {8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00});

        // R2 unused bits read zero
        set_reg(3, 8'hFF, "R2");
        check("R2", {48'd0, dow_o}, {48'd0, 8'h07});
        set_reg(1, 8'hD9, "R2");
        check("R2", {48'd0, min_o}, {48'd0, 8'h59});

        // R3 seconds and minutes carry
        set_reg(2, 8'h05, "R3");
        set_reg(0, 8'h59, "R3");
        run(T, "R3");
        check("R3", {40'd0, sec_o, min_o, hour_o}, {40'd0, 8'h00, 8'h00, 8'h06});

        // R5 12-hour noon and midnight
        set_reg(2, 8'h51, "R5"); set_reg(1, 8'h59, "R5"); set_reg(0, 8'h59, "R5");
        run(T, "R5");
        check("R5", {48'd0, hour_o}, {48'd0, 8'h72});
        set_reg(2, 8'h72, "R5"); set_reg(1, 8'h59, "R5"); set_reg(0, 8'h59, "R5");
        run(T, "R5");
        check("R5", {48'd0, hour_o}, {48'd0, 8'h61});
        set_reg(4, 8'h10, "R5"); set_reg(2, 8'h71, "R5"); set_reg(1, 8'h59, "R5"); set_reg(0, 8'h59, "R5");
        run(T, "R5");
        check("R5", {40'd0, hour_o, date_o, 8'h00}, {40'd0, 8'h52, 8'h11, 8'h00});

        // R4 and R9 24-hour midnight with day-of-week wrap
        set_reg(3, 8'h07, "R9"); set_reg(2, 8'h23, "R4"); set_reg(1, 8'h59, "R4"); set_reg(0, 8'h59, "R4");
        run(T, "R4");
        check("R9", {40'd0, hour_o, dow_o, 8'h00}, {40'd0, 8'h00, 8'h01, 8'h00});

        // R6 30- and 31-day months
        set_reg(5, 8'h04, "R6"); set_reg(4, 8'h30, "R6"); set_reg(2, 8'h23, "R6"); set_reg(1, 8'h59, "R6"); set_reg(0, 8'h59, "R6");
        run(T, "R6");
        check("R6", {40'd0, date_o, month_o, 8'h00}, {40'd0, 8'h01, 8'h05, 8'h00});
        set_reg(5, 8'h01, "R6"); set_reg(4, 8'h31, "R6"); set_reg(2, 8'h23, "R6"); set_reg(1, 8'h59, "R6"); set_reg(0, 8'h59, "R6");
        run(T, "R6");
        check("R6", {40'd0, date_o, month_o, 8'h00}, {40'd0, 8'h01, 8'h02, 8'h00});

        // R7 February with century flag 0 and 1
        set_reg(5, 8'h02, "R7"); set_reg(4, 8'h28, "R7"); set_reg(2, 8'h23, "R7"); set_reg(1, 8'h59, "R7"); set_reg(0, 8'h59, "R7");
        run(T, "R7");
        check("R7", {40'd0, date_o, month_o, 8'h00}, {40'd0, 8'h29, 8'h02, 8'h00});
        set_reg(2, 8'h23, "R7"); set_reg(1, 8'h59, "R7"); set_reg(0, 8'h59, "R7");
        run(T, "R7");
        check("R7", {40'd0, date_o, month_o, 8'h00}, {40'd0, 8'h01, 8'h03, 8'h00});
        set_reg(5, 8'h82, "R7"); set_reg(4, 8'h28, "R7"); set_reg(2, 8'h23, "R7"); set_reg(1, 8'h59, "R7"); set_reg(0, 8'h59, "R7");
        run(T, "R7");
        check("R7", {40'd0, date_o, month_o, 8'h00}, {40'd0, 8'h01, 8'h83, 8'h00});

        // R8 year and century rollover, both directions
        set_reg(6, 8'h99, "R8"); set_reg(5, 8'h12, "R8"); set_reg(4, 8'h31, "R8"); set_reg(2, 8'h23, "R8"); set_reg(1, 8'h59, "R8"); set_reg(0, 8'h59, "R8");
        run(T, "R8");
        check("R8", {32'd0, date_o, month_o, year_o, 8'h00}, {32'd0, 8'h01, 8'h81, 8'h00, 8'h00});
        set_reg(6, 8'h99, "R8"); set_reg(5, 8'h92, "R8"); set_reg(4, 8'h31, "R8"); set_reg(2, 8'h23, "R8"); set_reg(1, 8'h59, "R8"); set_reg(0, 8'h59, "R8");
        run(T, "R8");
        check("R8", {40'd0, month_o, year_o, 8'h00}, {40'd0, 8'h01, 8'h00, 8'h00});

        // R10 seconds write restarts the prescaler mid-count
        run(3, "R10");
        cycle(1'b1, 7'b0000001, 8'h10, 1'b1, "R10");
        run(T - 1, "R10");
        check("R10", {48'd0, sec_o}, {48'd0, 8'h10});
        run(1, "R10");
        check("R10", {48'd0, sec_o}, {48'd0, 8'h11});

        // R11 minutes write in the carry cycle wins, hours still carry
        set_reg(2, 8'h04, "R11"); set_reg(1, 8'h59, "R11"); set_reg(0, 8'h59, "R11");
        run(T - 1, "R11");
        cycle(1'b1, 7'b0000010, 8'h30, 1'b1, "R11");
        check("R11", {40'd0, sec_o, min_o, hour_o}, {40'd0, 8'h00, 8'h30, 8'h05});

        // Random phase: legal writes near boundaries mixed with ticks
        for (int i = 0; i < 6000; i++) begin
            if ($urandom_range(0, 15) == 0) begin
                int idx;
                logic [7:0] d;
                idx = $urandom_range(0, 6);
                case (idx)
                    0, 1: d = to_bcd($urandom_range(0, 1) ? $urandom_range(55, 59) : $urandom_range(0, 59));
                    2: d = hour_byte(1'($urandom_range(0, 1)), $urandom_range(0, 1) ? 11 + 12 * $urandom_range(0, 1) : $urandom_range(0, 23));
                    3: d = to_bcd($urandom_range(1, 7));
                    4: d = to_bcd($urandom_range(0, 1) ? days_in(m_mon, m_cent) : $urandom_range(1, 28));
                    5: d = {1'($urandom_range(0, 1)), 2'b00, to_bcd($urandom_range(1, 12))[4:0]};
                    default: d = to_bcd($urandom_range(0, 1) ? 99 : $urandom_range(0, 99));
                endcase
                cycle(1'($urandom_range(0, 1)), 7'(1 << idx), d, 1'b1, "R11");
            end else begin
                cycle(1'($urandom_range(0, 1)), '0, '0, 1'b1, "R3");
            end
        end

        // R12 illegal seconds value wraps on the next advance
        cycle(1'b0, 7'b0000001, 8'h7F, 1'b0, "R12");
        for (int i = 0; i < T; i++) cycle(1'b1, '0, '0, 1'b0, "R12");
        check("R12", {48'd0, sec_o}, {48'd0, 8'h00});
        for (int i = 0; i < T; i++) cycle(1'b1, '0, '0, 1'b0, "R12");
        check("R12", {48'd0, sec_o}, {48'd0, 8'h01});

        summary();
        $finish;
    end

endmodule